// File: doc/BRIEF.md
# Trip-Point Alarm Pin Controller

This block watches a running elapsed-time count and compares it against a programmed trip point. From that comparison it drives one active-low alarm pin. In steady mode the pin is pulled low for as long as the alarm holds. In flash mode the pin gives a burst of a fixed number of short low pulses. A burst can be started by a power-up pulse, by the alarm turning on, or by an outside agent pulling the pin low and then letting it go.

The same pin can also be turned round and used as an input. When the pin-select bit is 1, the block never drives the pin. Instead, a high level sensed on the pin is ORed with a configuration bit to form the reset-enable signal for the rest of the recorder.

The pulse widths are counted in strobes of an external slow timebase, so the timing is set by parameters. Every port is a plain control or status pin. No data stream crosses the block's edge, so there is no valid/ready handshake and no back-pressure.

Top module: `trip_alarm_ctl`

## Requirements
- R1: The alarm flag can only be 1 when the trip point is non-zero and `cfg_pin_is_rst` is 0. Otherwise the flag is 0 one clock later.
- R2: With `cfg_after_match`=1 and monitoring enabled, the flag is 1 one clock after `cnt_val >= trip_val`, using an unsigned compare, and 0 otherwise.
- R3: With `cfg_after_match`=0 and monitoring enabled, the flag is 1 one clock after `cnt_val < trip_val`, and 0 otherwise.
- R4: In steady mode (`cfg_pulse_mode`=0) with `cfg_pin_is_rst`=0, `pin_drive_low` equals the alarm flag.
- R5: A flash burst drives the pin low `PULSES` times. Each low lasts exactly `LOW_TICKS` strobes of `tick`. Each low is followed by `HIGH_TICKS` strobes released. The pin is then released and stays released.
- R6: In flash mode, a one-cycle `pwr_up` pulse starts a burst. In steady mode, `pwr_up` produces no pin activity.
- R7: In flash mode, the alarm flag going from 0 to 1 starts a burst. After the burst the pin is released even though the flag stays 1.
- R8: In flash mode, with no burst running, an outside low on the pin that the block did not cause starts a burst once the pin is sensed high again. The pin is not driven while it is held low from outside.
- R9: A trigger of any kind that arrives during a burst is ignored. The burst still has exactly `PULSES` lows, and no second burst follows.
- R10: With `cfg_pin_is_rst`=1 the pin is never driven. `reset_enable` equals `cfg_rst_en` OR the pin's sensed level, registered once. With `cfg_pin_is_rst`=0, `reset_enable` equals `cfg_rst_en`.
- R11: In both modes, the alarm flag reports the alarm condition and not the pin level.
- R12: While `rst_n` is low, `alarm_flag`, `pin_drive_low` and `reset_enable` (with `cfg_rst_en`=0) are 0, and any burst in progress is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | CW | Running elapsed-time count |
| trip_val | input | CW | Programmed trip point; 0 disables monitoring |
| cfg_pin_is_rst | input | 1 | 1: pin is a reset-enable input; 0: pin is the alarm output |
| cfg_pulse_mode | input | 1 | 1: flash bursts; 0: steady low level |
| cfg_after_match | input | 1 | 1: alarm from the match onward; 0: alarm until the match |
| cfg_rst_en | input | 1 | Reset-enable configuration bit |
| tick | input | 1 | One-cycle timebase strobe |
| pwr_up | input | 1 | One-cycle power-up indication |
| pin_sense | input | 1 | Sensed level of the shared pin |
| pin_drive_low | output | 1 | 1 pulls the shared pin low |
| alarm_flag | output | 1 | Alarm condition, read-only |
| reset_enable | output | 1 | Combined reset-enable |

## Verification
The comparison is exercised with random counts and trip points drawn from a small range, so that equality and the values one either side of it occur often. These are mixed with directed values near the top of the unsigned range, which separate an unsigned compare from a signed one, and with a zero trip point, which separates a disabled monitor from a trip point of zero. Both polarities and both pin roles are crossed with these values, which tells a wrong polarity apart from a wrong enable.

Each burst trigger is exercised on its own: power-up, alarm turn-on, and release of an outside pull. The bench counts the falling edges and the strobes seen while the pin is low. It also counts the strobes from the first fall to the last, which catches a wrong pulse count, a wrong low width or a wrong gap separately.

Extra triggers are injected mid-burst, and a reset is applied mid-burst, to show that nothing is queued and that nothing is kept across the reset.

// File: rtl/trip_alarm_pkg.sv
package trip_alarm_pkg;

  typedef struct packed {
    logic pin_is_rst;
    logic pulse_mode;
    logic after_match;
    logic rst_en;
  } ta_cfg_t;

  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } ta_phase_e;

endpackage

// File: rtl/ta_compare.sv
module ta_compare #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_val,
  input  logic [CW-1:0] trip_val,
  input  logic          pin_is_rst,
  input  logic          after_match,
  output logic          alarm_q,
  output logic          alarm_rise
);

  logic monitor_en;
  logic reached;
  logic active;

  assign monitor_en = (trip_val != '0) && !pin_is_rst;
  assign reached    = (cnt_val >= trip_val);
  assign active     = monitor_en && (after_match ? reached : !reached);
  assign alarm_rise = active && !alarm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alarm_q <= 1'b0;
    else        alarm_q <= active;
  end

endmodule

// File: rtl/ta_burst.sv
module ta_burst
  import trip_alarm_pkg::*;
#(
  parameter int PULSES     = 4,
  parameter int LOW_TICKS  = 1,
  parameter int HIGH_TICKS = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start,
  output logic busy,
  output logic low_out
);

  localparam int TMAX = (LOW_TICKS > HIGH_TICKS) ? LOW_TICKS : HIGH_TICKS;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int PW   = $clog2(PULSES + 1);
  localparam logic [TW-1:0] LOW_LAST   = TW'(LOW_TICKS - 1);
  localparam logic [TW-1:0] HIGH_LAST  = TW'(HIGH_TICKS - 1);
  localparam logic [TW-1:0] T_ONE      = TW'(1);
  localparam logic [PW-1:0] PIDX_LAST  = PW'(PULSES - 1);
  localparam logic [PW-1:0] P_ONE      = PW'(1);

  ta_phase_e     phase;
  logic [TW-1:0] tcnt;
  logic [PW-1:0] pidx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      phase <= PH_LOW;
      tcnt  <= '0;
      pidx  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy  <= 1'b1;
        phase <= PH_LOW;
        tcnt  <= '0;
        pidx  <= '0;
      end
    end else if (tick) begin
      if (phase == PH_LOW) begin
        if (tcnt == LOW_LAST) begin
          phase <= PH_HIGH;
          tcnt  <= '0;
        end else begin
          tcnt <= tcnt + T_ONE;
        end
      end else begin
        if (tcnt == HIGH_LAST) begin
          tcnt <= '0;
          if (pidx == PIDX_LAST) begin
            busy <= 1'b0;
          end else begin
            pidx  <= pidx + P_ONE;
            phase <= PH_LOW;
          end
        end else begin
          tcnt <= tcnt + T_ONE;
        end
      end
    end
  end

  assign low_out = busy && (phase == PH_LOW);

  AST_START_IGNORED_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !tick) |=> ($stable(pidx) && $stable(tcnt) && $stable(phase))); // R9

  AST_LOW_HELD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && phase == PH_LOW && !tick) |=> (busy && phase == PH_LOW)); // R5

  AST_PULSE_INDEX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (pidx <= PIDX_LAST)); // R5

endmodule

// File: rtl/ta_pin_watch.sv
module ta_pin_watch (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_sense,
  input  logic drive_now,
  input  logic watch_en,
  input  logic burst_busy,
  input  logic pin_is_rst,
  input  logic rst_en,
  output logic rel_trig,
  output logic reset_enable
);

  logic sense_q;
  logic drive_q;
  logic ext_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q <= 1'b1;
      drive_q <= 1'b0;
      ext_low <= 1'b0;
    end else begin
      sense_q <= pin_sense;
      drive_q <= drive_now;
      if (!watch_en || sense_q)
        ext_low <= 1'b0;
      else if (!burst_busy && !drive_q)
        ext_low <= 1'b1;
    end
  end

  assign rel_trig     = watch_en && ext_low && sense_q;
  assign reset_enable = rst_en || (pin_is_rst && sense_q);

  AST_RELEASE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rel_trig |=> !rel_trig); // R8

endmodule

// File: rtl/trip_alarm_ctl.sv
module trip_alarm_ctl
  import trip_alarm_pkg::*;
#(
  parameter int CW         = 32,
  parameter int PULSES     = 4,
  parameter int LOW_TICKS  = 1,
  parameter int HIGH_TICKS = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_val,
  input  logic [CW-1:0] trip_val,
  input  logic          cfg_pin_is_rst,
  input  logic          cfg_pulse_mode,
  input  logic          cfg_after_match,
  input  logic          cfg_rst_en,
  input  logic          tick,
  input  logic          pwr_up,
  input  logic          pin_sense,
  output logic          pin_drive_low,
  output logic          alarm_flag,
  output logic          reset_enable
);

  ta_cfg_t cfg;
  logic    alarm_q;
  logic    alarm_rise;
  logic    rel_trig;
  logic    burst_start;
  logic    burst_busy;
  logic    burst_low;
  logic    flash_out;

  assign cfg = '{pin_is_rst:  cfg_pin_is_rst,
                 pulse_mode:  cfg_pulse_mode,
                 after_match: cfg_after_match,
                 rst_en:      cfg_rst_en};

  assign flash_out = cfg.pulse_mode && !cfg.pin_is_rst;

  ta_compare #(.CW(CW)) u_cmp (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_val     (cnt_val),
    .trip_val    (trip_val),
    .pin_is_rst  (cfg.pin_is_rst),
    .after_match (cfg.after_match),
    .alarm_q     (alarm_q),
    .alarm_rise  (alarm_rise)
  );

  assign burst_start = flash_out && (pwr_up || alarm_rise || rel_trig);

  ta_burst #(
    .PULSES     (PULSES),
    .LOW_TICKS  (LOW_TICKS),
    .HIGH_TICKS (HIGH_TICKS)
  ) u_burst (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .start   (burst_start),
    .busy    (burst_busy),
    .low_out (burst_low)
  );

  ta_pin_watch u_watch (
    .clk          (clk),
    .rst_n        (rst_n),
    .pin_sense    (pin_sense),
    .drive_now    (pin_drive_low),
    .watch_en     (flash_out),
    .burst_busy   (burst_busy),
    .pin_is_rst   (cfg.pin_is_rst),
    .rst_en       (cfg.rst_en),
    .rel_trig     (rel_trig),
    .reset_enable (reset_enable)
  );

  assign alarm_flag    = alarm_q;
  assign pin_drive_low = !cfg.pin_is_rst && (cfg.pulse_mode ? burst_low : alarm_q);

  AST_INPUT_ROLE_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cfg_pin_is_rst)) |-> !alarm_flag); // R1

  AST_AFTER_MATCH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(trip_val != '0 && !cfg_pin_is_rst && cfg_after_match
                           && cnt_val >= trip_val)) |-> alarm_flag); // R2

  AST_UNTIL_MATCH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(!cfg_after_match && cnt_val >= trip_val)) |-> !alarm_flag); // R3

endmodule

// File: tb/trip_alarm_ctl_tb_top.sv
`timescale 1ns/1ps
module trip_alarm_ctl_tb_top;

  localparam int CW  = 32;
  localparam int NP  = 4;
  localparam int LT  = 2;
  localparam int HT  = 3;
  localparam int DIV = 4;
  localparam int BURST_WAIT = NP * (LT + HT) * DIV + 30;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [CW-1:0] cnt_val, trip_val;
  logic          cfg_pin_is_rst, cfg_pulse_mode, cfg_after_match, cfg_rst_en;
  logic          tick, pwr_up, ext_pull;
  logic          pin_sense, pin_drive_low, alarm_flag, reset_enable;

  always #4 clk = ~clk;

  assign pin_sense = !(pin_drive_low || ext_pull);

  trip_alarm_ctl #(.CW(CW), .PULSES(NP), .LOW_TICKS(LT), .HIGH_TICKS(HT)) dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .trip_val(trip_val),
    .cfg_pin_is_rst(cfg_pin_is_rst), .cfg_pulse_mode(cfg_pulse_mode),
    .cfg_after_match(cfg_after_match), .cfg_rst_en(cfg_rst_en),
    .tick(tick), .pwr_up(pwr_up), .pin_sense(pin_sense),
    .pin_drive_low(pin_drive_low), .alarm_flag(alarm_flag), .reset_enable(reset_enable)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  // monitor state
  int n_falls = 0;
  int ticks_total = 0;
  int ticks_low = 0;
  int stamp [64];
  bit prev_low = 0;
  int snap_f, snap_tl;

  task automatic chk(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_flag(logic [CW-1:0] c, logic [CW-1:0] t, bit sel, bit am);
    bit en;
    en = (t != 0) && !sel;
    return en && (am ? (c >= t) : (c < t));
  endfunction

  // timebase strobe
  initial begin
    int tdiv;
    tdiv = 0;
    tick = 1'b0;
    forever begin
      @(negedge clk);
      tdiv = (tdiv == DIV - 1) ? 0 : tdiv + 1;
      tick = (tdiv == 0);
    end
  end

  // pin monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (pin_drive_low && !prev_low) begin
        stamp[n_falls % 64] = ticks_total;
        n_falls++;
      end
      prev_low = pin_drive_low;
      if (tick) begin
        ticks_total++;
        if (pin_drive_low) ticks_low++;
      end
    end
  end

  task automatic set_in(logic [CW-1:0] c, logic [CW-1:0] t, bit sel, bit pm, bit am, bit re);
    @(negedge clk);
    cnt_val = c; trip_val = t;
    cfg_pin_is_rst = sel; cfg_pulse_mode = pm; cfg_after_match = am; cfg_rst_en = re;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
    #2;
  endtask

  task automatic snap();
    @(negedge clk);
    #2;
    snap_f = n_falls;
    snap_tl = ticks_low;
  endtask

  task automatic pulse_pwr();
    @(negedge clk); pwr_up = 1'b1;
    @(negedge clk); pwr_up = 1'b0;
  endtask

  task automatic check_burst(string req);
    int nf;
    repeat (BURST_WAIT) @(negedge clk);
    #2;
    nf = n_falls - snap_f;
    chk(req, "low pulse count", nf, NP);
    chk(req, "strobes while low", ticks_low - snap_tl, NP * LT);
    if (nf == NP)
      chk(req, "strobes first to last fall",
          stamp[(snap_f + NP - 1) % 64] - stamp[snap_f % 64], (NP - 1) * (LT + HT));
    chk(req, "pin released after burst", pin_drive_low, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5021));
    rst_n = 1'b0; ext_pull = 1'b0; pwr_up = 1'b0;
    cnt_val = '0; trip_val = '0;
    cfg_pin_is_rst = 0; cfg_pulse_mode = 0; cfg_after_match = 0; cfg_rst_en = 0;
    repeat (3) @(negedge clk);
    #2;
    chk("R12", "flag in reset", alarm_flag, 0);
    chk("R12", "pin in reset", pin_drive_low, 0);
    chk("R12", "reset_enable in reset", reset_enable, 0);
    @(negedge clk); rst_n = 1'b1;

    // R1: zero trip point disables monitoring
    set_in(32'd5, 32'd0, 0, 0, 1, 0); settle();
    chk("R1", "flag with zero trip", alarm_flag, 0);
    set_in(32'd5, 32'd3, 1, 0, 1, 0); settle();
    chk("R1", "flag with pin as input", alarm_flag, 0);
    chk("R10", "pin driven in input role", pin_drive_low, 0);

    // R2/R3 boundaries
    for (int pol = 0; pol < 2; pol++) begin
      for (int d = -1; d <= 1; d++) begin
        set_in(32'(100 + d), 32'd100, 0, 0, pol[0], 0); settle();
        chk(pol ? "R2" : "R3", "flag at boundary", alarm_flag, exp_flag(32'(100 + d), 32'd100, 0, pol[0]));
        chk("R4", "steady pin", pin_drive_low, alarm_flag);
      end
    end
    set_in(32'hFFFF_FFFF, 32'hFFFF_FFF0, 0, 0, 1, 0); settle();
    chk("R2", "unsigned high compare", alarm_flag, 1);
    set_in(32'h0000_0001, 32'hFFFF_FFF0, 0, 0, 0, 0); settle();
    chk("R3", "unsigned below trip", alarm_flag, 1);

    // R10 directed
    set_in(32'd0, 32'd0, 1, 0, 0, 0); @(negedge clk); ext_pull = 1'b0; settle();
    chk("R10", "sensed high enables", reset_enable, 1);
    @(negedge clk); ext_pull = 1'b1; settle();
    chk("R10", "sensed low disables", reset_enable, 0);
    set_in(32'd0, 32'd0, 1, 0, 0, 1); settle();
    chk("R10", "config bit ORed", reset_enable, 1);
    @(negedge clk); ext_pull = 1'b0;
    set_in(32'd0, 32'd0, 0, 0, 0, 0); settle();
    chk("R10", "output role ignores pin", reset_enable, 0);

    // random steady-mode sweep
    for (int i = 0; i < 80; i++) begin
      logic [CW-1:0] c, t;
      bit sel, am, re, ep;
      c = $urandom_range(0, 12);
      t = $urandom_range(0, 12);
      sel = ($urandom_range(0, 3) == 0);
      am = $urandom_range(0, 1);
      re = $urandom_range(0, 1);
      ep = sel ? $urandom_range(0, 1) : 0;
      set_in(c, t, sel, 0, am, re);
      ext_pull = ep;
      settle();
      chk(sel ? "R1" : (am ? "R2" : "R3"), "random flag", alarm_flag, exp_flag(c, t, sel, am));
      chk("R4", "random steady pin", pin_drive_low, exp_flag(c, t, sel, am));
      chk("R10", "random reset_enable", reset_enable, re | (sel & !ep));
    end
    @(negedge clk); ext_pull = 1'b0;
    settle();

    // R6: power-up in steady mode: nothing
    set_in(32'd0, 32'd0, 0, 0, 0, 0); settle();
    snap(); pulse_pwr(); repeat (40) @(negedge clk); #2;
    chk("R6", "steady mode ignores power-up", n_falls - snap_f, 0);

    // R6: power-up burst
    set_in(32'd0, 32'd0, 0, 1, 0, 0); settle();
    snap(); pulse_pwr(); check_burst("R6");

    // R7: alarm rise burst
    set_in(32'd90, 32'd100, 0, 1, 1, 0); settle();
    snap();
    set_in(32'd100, 32'd100, 0, 1, 1, 0);
    check_burst("R7");
    chk("R11", "flag stays set after burst", alarm_flag, 1);

    // R8: external pull and release
    set_in(32'd0, 32'd0, 0, 1, 0, 0); settle();
    snap();
    @(negedge clk); ext_pull = 1'b1;
    repeat (6) @(negedge clk);
    #2;
    chk("R8", "no drive while held from outside", n_falls - snap_f, 0);
    @(negedge clk); ext_pull = 1'b0;
    check_burst("R8");

    // R9: triggers during burst ignored
    settle();
    snap(); pulse_pwr();
    repeat (10) @(negedge clk);
    pulse_pwr();
    @(negedge clk); ext_pull = 1'b1;
    repeat (3) @(negedge clk);
    ext_pull = 1'b0;
    check_burst("R9");
    repeat (40) @(negedge clk); #2;
    chk("R9", "no queued second burst", n_falls - snap_f, NP);

    // R12: reset mid-burst, then R7 burst after reset
    set_in(32'd0, 32'd5, 0, 1, 0, 0); settle();
    chk("R11", "flag active before match in flash mode", alarm_flag, 1);
    snap(); pulse_pwr(); repeat (6) @(negedge clk);
    rst_n = 1'b0; #2;
    chk("R12", "flag cleared by reset", alarm_flag, 0);
    chk("R12", "pin released by reset", pin_drive_low, 0);
    @(negedge clk); #2;
    snap();
    rst_n = 1'b1;
    check_burst("R7");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule